// File: doc/BRIEF.md
# Infrared UART Status and Interrupt Controller

This block holds the flags, enables and interrupt masks that sit between an infrared UART's serial engine and the processor. The serial shifter and the pulse modulator live elsewhere. They reach this block through a few strobes: a received byte with its parity and framing indications, and a "shift finished" pulse from the transmitter. In the other direction, the block offers the next transmit byte with a one-cycle start pulse.

Software works through a small register file. It enables the transmitter or the receiver, loads transmit bytes and reads received ones. It also sees the status flags, a sticky error register and a per-source interrupt mask. The block combines the masked flags into one registered interrupt line. Driver code can then tell "transmit buffer free", "transmission fully drained" and "byte received or error" apart by the mask it has armed.

Top module: `irux_status_ctrl`

## Requirements
- R1: After reset, STATUS (address 1) reads 0x0003, CONTROL (address 0), MASK (address 5) and ERRLOG (address 2) read 0x0000, and `irq` is low.
- R2: CONTROL bit0 enables the transmitter and bit1 enables the receiver; bit2 is a command that empties the transmit buffer and always reads back as 0.
- R3: Only MASK bits 0 (transmit empty), 1 (shift empty), 2 (receive full) and 6 (summary error) are stored; the other bits read as 0.
- R4: When the receiver is enabled and the buffer is free, `rx_stb` stores `rx_byte`, sets STATUS bit2 and copies `rx_perr` into bit3 and `rx_ferr` into bit4. While the receiver is disabled, `rx_stb` has no effect.
- R5: An `rx_stb` that arrives while STATUS bit2 is set sets the overrun flag, STATUS bit5. The new byte and its error inputs are discarded.
- R6: STATUS bit6 is set whenever any of bits 3, 4 or 5 is set.
- R7: Reading RXDATA (address 4) returns the held byte in bits 7:0 and clears STATUS bits 2 to 6. A byte that is strobed in the same cycle is taken as if the buffer were already empty.
- R8: ERRLOG keeps a sticky copy of STATUS bits 3 to 6 at the same positions. An RXDATA read does not clear it. Only a write of 0x0000 clears it, and any other write is ignored.
- R9: A write to TXDATA (address 3) is taken only while STATUS bit0 (transmit empty) is 1. The write clears that bit, whatever the transmit enable is. Writes made while the buffer holds a byte are ignored.
- R10: While the transmitter is enabled, the buffer is full and STATUS bit1 (shift empty) is 1, `tx_start` is high for one cycle with the byte on `tx_byte`. After that, bit0 is 1 and bit1 is 0, and `sh_done` sets bit1 again. A transmission is complete only when both bits are 1.
- R11: Writing CONTROL with bit2 set empties the transmit buffer, which sets STATUS bit0, and no transfer takes place.
- R12: `irq` is registered. One cycle after the flags and mask, it equals the OR, over bits 0, 1, 2 and 6, of the mask bit ANDed with the STATUS bit.
- R13: Writes to STATUS are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (side effects on RXDATA) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from the address |
| rx_stb | input | 1 | Received byte strobe from the shifter |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error of the strobed byte |
| rx_ferr | input | 1 | Framing error of the strobed byte |
| tx_start | output | 1 | Hand-off pulse to the transmit shifter |
| tx_byte | output | 8 | Transmit buffer contents |
| sh_done | input | 1 | Transmit shifter finished its byte |
| irq | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach is an RXDATA read that falls in the same cycle as a new receive strobe. Whether that byte lands cleanly or counts as an overrun depends on which of the two the logic treats as first. The bench sets up a full buffer and then drives the read and the strobe in the same cycle. It checks that the old byte is returned, that no overrun appears, and that the new byte and its parity error take the freed slot. A second hard case is telling a buffer-empty transmitter from a drained one. For this the bench holds the shifter busy with `sh_done` while it loads a second byte.

// File: rtl/irux_status_ctrl.sv
module irux_status_ctrl #(
  parameter int DW = 8,
  parameter int RW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [AW-1:0] reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          rx_stb,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  output logic          tx_start,
  output logic [DW-1:0] tx_byte,
  input  logic          sh_done,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_ELOG = AW'(2);
  localparam logic [AW-1:0] A_TXD  = AW'(3);
  localparam logic [AW-1:0] A_RXD  = AW'(4);
  localparam logic [AW-1:0] A_MASK = AW'(5);
  localparam int NFLAG = 7;

  logic          tx_en_q, rx_en_q;
  logic          tx_empty_q, sh_empty_q;
  logic          rx_full_q, perr_q, ferr_q, ovr_q;
  logic [3:0]    elog_q;
  logic [3:0]    mask_q;
  logic [DW-1:0] rx_buf_q, tx_buf_q;
  logic          irq_q;

  wire wr_ctrl = reg_we && reg_addr == A_CTRL;
  wire wr_elog = reg_we && reg_addr == A_ELOG;
  wire wr_txd  = reg_we && reg_addr == A_TXD;
  wire wr_mask = reg_we && reg_addr == A_MASK;
  wire rd_rx   = reg_re && reg_addr == A_RXD;
  wire tx_clr  = wr_ctrl && reg_wdata[2];
  wire rx_acc  = rx_stb && rx_en_q;
  wire rx_take = rx_acc && (!rx_full_q || rd_rx);
  wire rx_lost = rx_acc && rx_full_q && !rd_rx;
  wire sum_err = perr_q | ferr_q | ovr_q;

  wire [NFLAG-1:0] flags = {sum_err, ovr_q, ferr_q, perr_q, rx_full_q, sh_empty_q, tx_empty_q};
  wire [3:0] ev_err = {rx_lost || (rx_take && (rx_perr || rx_ferr)), rx_lost,
                       rx_take && rx_ferr, rx_take && rx_perr};

  assign tx_start = tx_en_q && !tx_empty_q && sh_empty_q;
  assign tx_byte  = tx_buf_q;
  assign irq      = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_en_q <= reg_wdata[0];
        rx_en_q <= reg_wdata[1];
      end
      if (wr_mask) mask_q <= {reg_wdata[6], reg_wdata[2:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_empty_q <= 1'b1;
      sh_empty_q <= 1'b1;
      tx_buf_q   <= '0;
    end else begin
      if (tx_clr || tx_start) tx_empty_q <= 1'b1;
      else if (wr_txd && tx_empty_q) begin
        tx_empty_q <= 1'b0;
        tx_buf_q   <= reg_wdata[DW-1:0];
      end
      if (tx_start) sh_empty_q <= 1'b0;
      else if (sh_done) sh_empty_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_full_q <= 1'b0;
      perr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      ovr_q     <= 1'b0;
      rx_buf_q  <= '0;
    end else if (rx_take) begin
      rx_full_q <= 1'b1;
      rx_buf_q  <= rx_byte;
      perr_q    <= rx_perr;
      ferr_q    <= rx_ferr;
      ovr_q     <= 1'b0;
    end else if (rx_lost) begin
      ovr_q <= 1'b1;
    end else if (rd_rx) begin
      rx_full_q <= 1'b0;
      perr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      ovr_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) elog_q <= '0;
    else elog_q <= ((wr_elog && reg_wdata == '0) ? 4'b0 : elog_q) | ev_err;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else irq_q <= |(mask_q & {sum_err, rx_full_q, sh_empty_q, tx_empty_q});
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[1:0] = {rx_en_q, tx_en_q};
      A_STAT: reg_rdata[NFLAG-1:0] = flags;
      A_ELOG: reg_rdata[6:3] = elog_q;
      A_TXD:  reg_rdata[DW-1:0] = tx_buf_q;
      A_RXD:  reg_rdata[DW-1:0] = rx_buf_q;
      A_MASK: begin
        reg_rdata[2:0] = mask_q[2:0];
        reg_rdata[6]   = mask_q[3];
      end
      default: reg_rdata = '0;
    endcase
  end

  a_r5_overrun_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rx_acc && rx_full_q && !rd_rx |=> ovr_q && rx_full_q && $stable(rx_buf_q));
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rx && !rx_acc |=> !rx_full_q && !perr_q && !ferr_q && !ovr_q);
  a_r10_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> tx_empty_q && !sh_empty_q && !tx_start);
  a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> tx_empty_q);
  a_r12_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q == 4'b0 |=> !irq);
  a_r4_rx_off_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_q |=> $stable(rx_buf_q));
  a_r8_log_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_elog && reg_wdata == '0) |=> (elog_q & $past(elog_q)) == $past(elog_q));
endmodule

// File: tb/tb_irux_status_ctrl.sv
module tb_irux_status_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, reg_re = 0, rx_stb = 0, rx_perr = 0, rx_ferr = 0, sh_done = 0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [7:0] rx_byte = '0;
  logic [15:0] reg_rdata;
  logic tx_start, irq;
  logic [7:0] tx_byte;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irux_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_stb(rx_stb), .rx_byte(rx_byte),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .tx_start(tx_start), .tx_byte(tx_byte),
    .sh_done(sh_done), .irq(irq));

  localparam int NOP = 0, WR = 1, RD = 2, RXB = 3, DONE = 4, IRQ = 5, TXS = 6;
  localparam int NV = 60;
  // {op, addr, data, expected, requirement}
  localparam logic [41:0] VEC [NV] = '{
    {3'd2, 3'd1, 16'h0000, 16'h0003, 4'd1},  // R1
    {3'd2, 3'd5, 16'h0000, 16'h0000, 4'd1},  // R1
    {3'd1, 3'd0, 16'h0003, 16'h0000, 4'd2},
    {3'd2, 3'd0, 16'h0000, 16'h0003, 4'd2},  // R2
    {3'd1, 3'd5, 16'h00FF, 16'h0000, 4'd3},
    {3'd2, 3'd5, 16'h0000, 16'h0047, 4'd3},  // R3
    {3'd5, 3'd0, 16'h0000, 16'h0001, 4'd12}, // R12
    {3'd1, 3'd5, 16'h0004, 16'h0000, 4'd12},
    {3'd0, 3'd0, 16'h0000, 16'h0000, 4'd12},
    {3'd5, 3'd0, 16'h0000, 16'h0000, 4'd12}, // R12
    {3'd3, 3'd0, 16'h005A, 16'h0000, 4'd4},
    {3'd2, 3'd1, 16'h0000, 16'h0007, 4'd4},  // R4
    {3'd5, 3'd0, 16'h0000, 16'h0001, 4'd12}, // R12
    {3'd3, 3'd0, 16'h0133, 16'h0000, 4'd5},
    {3'd2, 3'd1, 16'h0000, 16'h0067, 4'd5},  // R5 R6
    {3'd2, 3'd2, 16'h0000, 16'h0060, 4'd8},  // R8
    {3'd2, 3'd4, 16'h0000, 16'h005A, 4'd5},  // R5 byte kept
    {3'd2, 3'd1, 16'h0000, 16'h0003, 4'd7},  // R7
    {3'd2, 3'd2, 16'h0000, 16'h0060, 4'd8},  // R8
    {3'd1, 3'd2, 16'h0001, 16'h0000, 4'd8},
    {3'd2, 3'd2, 16'h0000, 16'h0060, 4'd8},  // R8
    {3'd1, 3'd2, 16'h0000, 16'h0000, 4'd8},
    {3'd2, 3'd2, 16'h0000, 16'h0000, 4'd8},  // R8
    {3'd3, 3'd0, 16'h02A5, 16'h0000, 4'd4},
    {3'd2, 3'd1, 16'h0000, 16'h0057, 4'd6},  // R6
    {3'd2, 3'd4, 16'h0000, 16'h00A5, 4'd7},  // R7
    {3'd3, 3'd0, 16'h013C, 16'h0000, 4'd4},
    {3'd2, 3'd1, 16'h0000, 16'h004F, 4'd4},  // R4
    {3'd2, 3'd4, 16'h0000, 16'h003C, 4'd7},  // R7
    {3'd1, 3'd3, 16'h00C3, 16'h0000, 4'd9},
    {3'd6, 3'd0, 16'h0000, 16'h0187, 4'd10}, // R10
    {3'd2, 3'd1, 16'h0000, 16'h0001, 4'd10}, // R10
    {3'd6, 3'd0, 16'h0000, 16'h0186, 4'd10}, // R10
    {3'd1, 3'd3, 16'h0044, 16'h0000, 4'd9},
    {3'd6, 3'd0, 16'h0000, 16'h0088, 4'd10}, // R10
    {3'd2, 3'd1, 16'h0000, 16'h0000, 4'd9},  // R9
    {3'd1, 3'd3, 16'h0099, 16'h0000, 4'd9},
    {3'd4, 3'd0, 16'h0000, 16'h0000, 4'd10},
    {3'd6, 3'd0, 16'h0000, 16'h0089, 4'd9},  // R9 ignored write
    {3'd2, 3'd1, 16'h0000, 16'h0001, 4'd10}, // R10
    {3'd1, 3'd5, 16'h0002, 16'h0000, 4'd12},
    {3'd0, 3'd0, 16'h0000, 16'h0000, 4'd12},
    {3'd5, 3'd0, 16'h0000, 16'h0000, 4'd12}, // R12
    {3'd4, 3'd0, 16'h0000, 16'h0000, 4'd10},
    {3'd0, 3'd0, 16'h0000, 16'h0000, 4'd12},
    {3'd5, 3'd0, 16'h0000, 16'h0001, 4'd12}, // R12
    {3'd1, 3'd0, 16'h0001, 16'h0000, 4'd4},
    {3'd3, 3'd0, 16'h0077, 16'h0000, 4'd4},
    {3'd2, 3'd1, 16'h0000, 16'h0003, 4'd4},  // R4 rx off
    {3'd1, 3'd0, 16'h0000, 16'h0000, 4'd9},
    {3'd1, 3'd3, 16'h0011, 16'h0000, 4'd9},
    {3'd2, 3'd1, 16'h0000, 16'h0002, 4'd9},  // R9
    {3'd6, 3'd0, 16'h0000, 16'h0022, 4'd2},  // R2 tx off
    {3'd1, 3'd0, 16'h0004, 16'h0000, 4'd11},
    {3'd2, 3'd1, 16'h0000, 16'h0003, 4'd11}, // R11
    {3'd2, 3'd0, 16'h0000, 16'h0000, 4'd2},  // R2
    {3'd1, 3'd0, 16'h0001, 16'h0000, 4'd11},
    {3'd6, 3'd0, 16'h0000, 16'h0022, 4'd11}, // R11
    {3'd1, 3'd1, 16'h0000, 16'h0000, 4'd13},
    {3'd2, 3'd1, 16'h0000, 16'h0003, 4'd13}  // R13
  };

  task automatic chk(input logic ok, input logic [15:0] act, input logic [15:0] exp, input int r);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step(input int op, input int a, input logic [15:0] d, input logic [15:0] e, input int r);
    @(negedge clk);
    reg_we = 0; reg_re = 0; rx_stb = 0; sh_done = 0; rx_perr = 0; rx_ferr = 0;
    reg_addr = 3'(a); reg_wdata = d;
    case (op)
      WR:   reg_we = 1;
      RD:   reg_re = 1;
      RXB:  begin rx_stb = 1; rx_byte = d[7:0]; rx_perr = d[8]; rx_ferr = d[9]; end
      DONE: sh_done = 1;
      default: ;
    endcase
    #1;
    case (op)
      RD:  chk(reg_rdata == e, reg_rdata, e, r);
      IRQ: chk(irq == e[0], {15'b0, irq}, e, r);
      TXS: chk({tx_byte, tx_start} == e[8:0], {7'b0, tx_byte, tx_start}, e, r);
      default: ;
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NV; i++)
      step(int'(VEC[i][41:39]), int'(VEC[i][38:36]), VEC[i][35:20], VEC[i][19:4], int'(VEC[i][3:0]));
    // R7 collision: read and strobe in the same cycle
    step(WR, 0, 16'h0002, 0, 7);
    step(WR, 5, 16'h0040, 0, 12);
    step(RXB, 0, 16'h0081, 0, 7);
    @(negedge clk);
    reg_we = 0; reg_re = 1; reg_addr = 3'd4; rx_stb = 1; rx_byte = 8'h55; rx_perr = 1; rx_ferr = 0;
    #1 chk(reg_rdata == 16'h0081, reg_rdata, 16'h0081, 7); // R7 old byte returned
    step(RD, 1, 0, 16'h004F, 7);   // R7 new byte taken, no overrun
    step(IRQ, 0, 0, 16'h0001, 12); // R12 summary-error mask
    step(RD, 4, 0, 16'h0055, 7);   // R7
    // R1 reset from a busy state
    @(negedge clk);
    reg_re = 0; rx_stb = 0; rx_perr = 0; rst_n = 0;
    @(negedge clk);
    #1;
    reg_addr = 3'd1; #1 chk(reg_rdata == 16'h0003, reg_rdata, 16'h0003, 1);
    reg_addr = 3'd2; #1 chk(reg_rdata == 16'h0000, reg_rdata, 16'h0000, 1);
    reg_addr = 3'd5; #1 chk(reg_rdata == 16'h0000, reg_rdata, 16'h0000, 1);
    reg_addr = 3'd0; #1 chk(reg_rdata == 16'h0000, reg_rdata, 16'h0000, 1);
    chk(irq == 1'b0, {15'b0, irq}, 16'h0000, 1);
    rst_n = 1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R0 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule